// File: doc/BRIEF.md
# UART Register, Receive Queue and Interrupt Block

This block is the processor-facing half of a serial port. It keeps a sixteen-entry circular queue of received bytes, a status flag word, a programmable receive threshold, and a set of interrupt registers: raw status, enable mask, masked status and a write-one-to-clear register. It also stores the divisor, line-setting, control, threshold-select and DMA-control words so that software can read them back. The top eight words of the address space form a read-only identification window. Serial shifting and baud timing live elsewhere. The serialiser hands in each received byte with a one-cycle valid strobe. A write to the data word sends the byte out on a one-cycle valid strobe.

The bus is word-addressed with separate read and write strobes. Read data is registered and appears on the cycle after the read strobe. A read of the data word consumes the oldest queued byte on that same edge. A single interrupt output is high whenever any enabled raw interrupt is pending. When queue mode is switched off in the line-setting word, the queue acts as a one-byte holding register with a threshold of one.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the flag word (word 6) reads 0x90: bit 7 is transmit-empty and bit 4 is receive-empty, while bit 6 (receive full) and bit 5 (transmit full) are clear. Raw status (word 15) and mask (word 14) read 0, irq is low, and queue mode (line-setting word 11, bit 4) is off.
- R2: Word addresses 0x3F8 to 0x3FF read back 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order, in bits 7:0.
- R3: The configuration words read back what was written, limited to their widths: word 8 has 8 bits, word 9 has 16, word 10 has 6, word 11 has 8, word 12 has 16, word 13 has 6, word 18 has 3, and word 14 keeps only bits 5:4. A write to the flag word has no effect.
- R4: With queue mode on, up to 16 bytes are held and read back in arrival order, including across the wrap of the circular store. Flag bit 6 is set only while 16 bytes are held, and flag bit 4 is set only while none are held. A byte that arrives while the queue is full is dropped.
- R5: With queue mode off, one byte is held. Flag bit 6 sets as soon as that byte arrives, and further bytes are dropped until it is read.
- R6: Raw status bit 4 (receive) sets on the arrival that brings the fill count equal to the threshold. In queue mode the threshold is 4 times bits 5:3 of word 13, so a value of 0 or one above 16 never fires. With queue mode off the threshold is 1.
- R7: Raw receive status clears when a data read leaves the fill count at threshold minus one. Otherwise it holds until it is cleared.
- R8: A data read with the queue empty returns the most recently accepted byte and leaves the fill count unchanged.
- R9: A write to word 0 drives tx_valid high for exactly one cycle, one cycle after the write strobe, with tx_byte equal to bits 7:0 of the write. It also sets raw status bit 5 (transmit).
- R10: Writing word 17 clears each raw status bit whose write-data bit is 1, for bits 5 and 4. Word 16 reads raw AND mask, and irq is high exactly when that value is nonzero.
- R11: Read data appears on bus_rdata on the cycle after bus_rd. A data read returns the oldest held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (10) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps all eight threshold selections in queue mode and shifts the read position before each pass, so the circular store wraps at a different point every time. At each arrival and each read it compares the receive interrupt with a threshold computed arithmetically. A design that compared with greater-or-equal, or cleared at the wrong count, would set or release the interrupt one entry early or late. A design that mishandled thresholds of zero or above sixteen would raise it when it should never fire. An extra byte offered at full must not overwrite the oldest entry or corrupt the order. The single-byte mode is checked for dropped second arrivals, and the empty-queue read for returning a stale slot instead of the last accepted byte.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;

  // Word indices of the register map.
  localparam int unsigned IX_DATA  = 0;
  localparam int unsigned IX_FLAGS = 6;
  localparam int unsigned IX_LPDIV = 8;
  localparam int unsigned IX_IDIV  = 9;
  localparam int unsigned IX_FDIV  = 10;
  localparam int unsigned IX_LINE  = 11;
  localparam int unsigned IX_CTRL  = 12;
  localparam int unsigned IX_LVL   = 13;
  localparam int unsigned IX_MASK  = 14;
  localparam int unsigned IX_RAW   = 15;
  localparam int unsigned IX_MIS   = 16;
  localparam int unsigned IX_ICLR  = 17;
  localparam int unsigned IX_DMA   = 18;

  // Flag word bits.
  localparam int unsigned FB_TXE = 7;
  localparam int unsigned FB_RXF = 6;
  localparam int unsigned FB_TXF = 5;
  localparam int unsigned FB_RXE = 4;

  // Interrupt bit positions in the status words.
  localparam int unsigned IB_TX = 5;
  localparam int unsigned IB_RX = 4;

  // Line-setting bit that turns the receive queue on.
  localparam int unsigned LB_QEN = 4;

  typedef struct packed {
    logic tx;
    logic rx;
  } irq_pair_t;

  function automatic logic [BYTE_W-1:0] ident_byte(input logic [2:0] k);
    logic [BYTE_W-1:0] v;
    case (k)
      3'd0: v = 8'h11;
      3'd1: v = 8'h10;
      3'd2: v = 8'h14;
      3'd3: v = 8'h00;
      3'd4: v = 8'h0D;
      3'd5: v = 8'hF0;
      3'd6: v = 8'h05;
      default: v = 8'hB1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ufifo_ring.sv
// Circular receive store: read pointer plus fill count, no write pointer.
// DEPTH must be a power of two so that the slot index wraps by truncation.
module ufifo_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          one_slot,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [DW-1:0] head,
  output logic [CW-1:0] fill
);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cap;
  logic [PW-1:0] wr_slot;

  always_comb begin
    cap     = one_slot ? CW'(1) : CW'(DEPTH);
    push_ok = push && (fill < cap);
    pop_ok  = pop && (fill != '0);
    wr_slot = rd_ptr + fill[PW-1:0];
  end

  // Storage without reset so it can map onto RAM resources.
  always_ff @(posedge clk) begin
    if (push_ok) store[wr_slot] <= push_data;
  end

  assign head = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (pop_ok) rd_ptr <= rd_ptr + PW'(1);
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/urx_trigger.sv
// Receive threshold and the events that set or release the receive interrupt.
module urx_trigger #(
  parameter int unsigned CW = 5
) (
  input  logic          queue_on,
  input  logic [2:0]    lvl_sel,
  input  logic [CW-1:0] fill,
  input  logic          push_ok,
  input  logic          pop_ok,
  output logic          hit_set,
  output logic          hit_clr
);

  localparam int unsigned TW = 6;

  logic [TW-1:0] thresh;
  int            fill_i;
  int            thr_i;

  always_comb begin
    thresh  = queue_on ? {1'b0, lvl_sel, 2'b00} : TW'(1);
    fill_i  = int'(fill);
    thr_i   = int'(thresh);
    // Arrival that lands exactly on the threshold.
    hit_set = push_ok && !pop_ok && ((fill_i + 1) == thr_i);
    // Read that leaves threshold minus one entries.
    hit_clr = pop_ok && !push_ok && (fill_i == thr_i) && (thr_i != 0);
  end

endmodule

// File: rtl/ucfg_regs.sv
// Stored configuration words with their readback.
module ucfg_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata,
  output logic              queue_on,
  output logic [2:0]        lvl_sel,
  output irq_pair_t         mask
);

  logic [7:0]  lp_div;
  logic [15:0] int_div;
  logic [5:0]  frac_div;
  logic [7:0]  line_cfg;
  logic [15:0] ctrl_cfg;
  logic [5:0]  lvl_cfg;
  logic [2:0]  dma_cfg;
  irq_pair_t   mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_div   <= '0;
      int_div  <= '0;
      frac_div <= '0;
      line_cfg <= '0;
      ctrl_cfg <= '0;
      lvl_cfg  <= '0;
      dma_cfg  <= '0;
      mask_q   <= '0;
    end else if (wr) begin
      if (addr == AW'(IX_LPDIV)) lp_div   <= wdata[7:0];
      if (addr == AW'(IX_IDIV))  int_div  <= wdata[15:0];
      if (addr == AW'(IX_FDIV))  frac_div <= wdata[5:0];
      if (addr == AW'(IX_LINE))  line_cfg <= wdata[7:0];
      if (addr == AW'(IX_CTRL))  ctrl_cfg <= wdata[15:0];
      if (addr == AW'(IX_LVL))   lvl_cfg  <= wdata[5:0];
      if (addr == AW'(IX_DMA))   dma_cfg  <= wdata[2:0];
      if (addr == AW'(IX_MASK))  mask_q   <= '{tx: wdata[IB_TX], rx: wdata[IB_RX]};
    end
  end

  always_comb begin
    hit   = 1'b1;
    rdata = '0;
    if      (addr == AW'(IX_LPDIV)) rdata[7:0]  = lp_div;
    else if (addr == AW'(IX_IDIV))  rdata[15:0] = int_div;
    else if (addr == AW'(IX_FDIV))  rdata[5:0]  = frac_div;
    else if (addr == AW'(IX_LINE))  rdata[7:0]  = line_cfg;
    else if (addr == AW'(IX_CTRL))  rdata[15:0] = ctrl_cfg;
    else if (addr == AW'(IX_LVL))   rdata[5:0]  = lvl_cfg;
    else if (addr == AW'(IX_DMA))   rdata[2:0]  = dma_cfg;
    else if (addr == AW'(IX_MASK)) begin
      rdata[IB_TX] = mask_q.tx;
      rdata[IB_RX] = mask_q.rx;
    end else hit = 1'b0;
  end

  assign queue_on = line_cfg[LB_QEN];
  assign lvl_sel  = lvl_cfg[5:3];
  assign mask     = mask_q;

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int unsigned AW    = 10,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);

  logic              cfg_hit;
  logic [DATA_W-1:0] cfg_rdata;
  logic              queue_on;
  logic [2:0]        lvl_sel;
  irq_pair_t         mask;

  logic              data_sel;
  logic              pop_req;
  logic              push_ok;
  logic              pop_ok;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     fill;
  logic              hit_set;
  logic              hit_clr;

  irq_pair_t         raw_q;
  irq_pair_t         raw_d;
  logic [BYTE_W-1:0] last_rx;
  logic              id_hit;
  logic [DATA_W-1:0] rd_val;
  logic [7:0]        flags;
  logic              tx_wr;
  logic              clr_wr;

  ucfg_regs #(.AW(AW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .hit      (cfg_hit),
    .rdata    (cfg_rdata),
    .queue_on (queue_on),
    .lvl_sel  (lvl_sel),
    .mask     (mask)
  );

  assign data_sel = (bus_addr == AW'(IX_DATA));
  assign pop_req  = bus_rd && data_sel;
  assign tx_wr    = bus_wr && data_sel;
  assign clr_wr   = bus_wr && (bus_addr == AW'(IX_ICLR));

  ufifo_ring #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .one_slot  (!queue_on),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (pop_req),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .head      (head),
    .fill      (fill)
  );

  urx_trigger #(.CW(CW)) u_trig (
    .queue_on (queue_on),
    .lvl_sel  (lvl_sel),
    .fill     (fill),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .hit_set  (hit_set),
    .hit_clr  (hit_clr)
  );

  // Next raw interrupt state: clear request first, then new events win.
  always_comb begin
    raw_d = raw_q;
    if (clr_wr) begin
      if (bus_wdata[IB_TX]) raw_d.tx = 1'b0;
      if (bus_wdata[IB_RX]) raw_d.rx = 1'b0;
    end
    if (hit_clr) raw_d.rx = 1'b0;
    if (hit_set) raw_d.rx = 1'b1;
    if (tx_wr)   raw_d.tx = 1'b1;
  end

  always_comb begin
    flags         = '0;
    flags[FB_TXE] = 1'b1;
    flags[FB_TXF] = 1'b0;
    flags[FB_RXE] = (fill == '0);
    flags[FB_RXF] = queue_on ? (fill == CW'(DEPTH)) : (fill != '0);
  end

  assign id_hit = (bus_addr[AW-1:3] == '1);

  always_comb begin
    rd_val = '0;
    if (id_hit) begin
      rd_val[7:0] = ident_byte(bus_addr[2:0]);
    end else if (cfg_hit) begin
      rd_val = cfg_rdata;
    end else if (data_sel) begin
      rd_val[7:0] = (fill == '0) ? last_rx : head;
    end else if (bus_addr == AW'(IX_FLAGS)) begin
      rd_val[7:0] = flags;
    end else if (bus_addr == AW'(IX_RAW)) begin
      rd_val[IB_TX] = raw_q.tx;
      rd_val[IB_RX] = raw_q.rx;
    end else if (bus_addr == AW'(IX_MIS)) begin
      rd_val[IB_TX] = raw_q.tx & mask.tx;
      rd_val[IB_RX] = raw_q.rx & mask.rx;
    end
  end

  // The next mask value is needed so irq tracks a mask write on the same edge.
  irq_pair_t mask_d;
  always_comb begin
    mask_d = mask;
    if (bus_wr && bus_addr == AW'(IX_MASK))
      mask_d = '{tx: bus_wdata[IB_TX], rx: bus_wdata[IB_RX]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= '0;
      last_rx   <= '0;
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      irq       <= 1'b0;
    end else begin
      raw_q    <= raw_d;
      tx_valid <= tx_wr;
      irq      <= |(raw_d & mask_d);
      if (push_ok) last_rx <= rx_byte;
      if (tx_wr)   tx_byte <= bus_wdata[BYTE_W-1:0];
      if (bus_rd)  bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int unsigned AW    = 10,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          rx_valid,
  input logic          tx_valid,
  input logic          irq,
  input logic [CW-1:0] fill,
  input logic [1:0]    raw,
  input logic [1:0]    mask,
  input logic          queue_on
);

  logic pop_req;
  assign pop_req = bus_rd && (bus_addr == '0);

  // R4: fill never exceeds the store depth.
  a_r4_fill_cap: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  // R4: an arrival at full without a read leaves the fill unchanged.
  a_r4_drop_full: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH) && rx_valid && !pop_req) |=> $stable(fill));

  // R5: in single-byte mode a held byte is never joined by another.
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    (!queue_on && fill <= CW'(1)) |=> (fill <= CW'(1) || $past(queue_on) != queue_on));

  // R9: a transmit strobe only follows a data-word write.
  a_r9_tx_src: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_wr && bus_addr == '0));

  // R10: the interrupt follows the enabled raw status.
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw & mask));

  // R6: the receive status only rises after an arrival.
  a_r6_rx_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(raw[0]) |-> $past(rx_valid));

endmodule

bind uart_regfile uart_regfile_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .rx_valid (rx_valid),
  .tx_valid (tx_valid),
  .irq      (irq),
  .fill     (fill),
  .raw      (raw_q),
  .mask     (mask),
  .queue_on (queue_on)
);

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;

  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] idv [8];
    idv = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(6, v);  check("R1 flags", v, 32'h90);
    rd(15, v); check("R1 raw", v, 32'h0);
    rd(14, v); check("R1 mask", v, 32'h0);
    rd(11, v); check("R1 line", v, 32'h0);

    // R2 identification window
    for (int k = 0; k < 8; k++) begin
      rd(32'h3F8 + k, v);
      check("R2 ident", v, {24'b0, idv[k]});
    end

    // R3 configuration readback widths
    wr(8, 32'hFFFF_FFFF);  rd(8, v);  check("R3 lpdiv", v, 32'hFF);
    wr(9, 32'hFFFF_FFFF);  rd(9, v);  check("R3 idiv", v, 32'hFFFF);
    wr(10, 32'hFFFF_FFFF); rd(10, v); check("R3 fdiv", v, 32'h3F);
    wr(12, 32'hFFFF_FFFF); rd(12, v); check("R3 ctrl", v, 32'hFFFF);
    wr(13, 32'hFFFF_FFFF); rd(13, v); check("R3 lvl", v, 32'h3F);
    wr(18, 32'hFFFF_FFFF); rd(18, v); check("R3 dma", v, 32'h7);
    wr(11, 32'h0000_00EF); rd(11, v); check("R3 line", v, 32'hEF);
    wr(14, 32'hFFFF_FFFF); rd(14, v); check("R3 mask", v, 32'h30);
    wr(14, 0); wr(11, 0);
    wr(6, 32'h0); rd(6, v); check("R3 flags ro", v, 32'h90);

    // R5 single-byte mode, threshold 1 (R6), release at 0 (R7)
    push(8'hA1);
    rd(6, v);  check("R5 full after one", v, 32'hC0);
    rd(15, v); check("R6 rx raw set at 1", v, 32'h10);
    push(8'hB2);
    rd(0, v);  check("R5 second dropped R11", v, 32'hA1);
    rd(6, v);  check("R5 empty", v, 32'h90);
    rd(15, v); check("R7 rx raw released", v, 32'h0);
    rd(0, v);  check("R8 empty read last", v, 32'hA1);
    rd(6, v);  check("R8 fill unchanged", v, 32'h90);

    // R4 / R6 / R7 sweep of all threshold selections in queue mode
    wr(11, 32'h10);
    for (int sel = 0; sel < 8; sel++) begin
      int thr;
      bit exp_rx;
      thr = 4 * sel;
      wr(13, sel << 3);
      for (int s = 0; s <= sel; s++) push(8'hEE);
      for (int s = 0; s <= sel; s++) rd(0, v);
      wr(17, 32'h30);
      exp_rx = 0;
      for (int k = 1; k <= 16; k++) begin
        push(8'((sel * 17 + k) & 8'hFF));
        if (k == thr) exp_rx = 1;
        rd(15, v); check("R6 rx raw on fill", v, exp_rx ? 32'h10 : 32'h0);
        if (k == 15) begin
          rd(6, v); check("R4 flags mid", v, 32'h80);
        end
      end
      rd(6, v); check("R4 full flag", v, 32'hC0);
      push(8'h5C);
      for (int c = 15; c >= 0; c--) begin
        rd(0, v);
        check("R4 order R11", v, {24'b0, 8'((sel * 17 + (16 - c)) & 8'hFF)});
        if (c == thr - 1) exp_rx = 0;
        rd(15, v); check("R7 rx raw on drain", v, exp_rx ? 32'h10 : 32'h0);
      end
      rd(6, v); check("R4 empty flag", v, 32'h90);
      rd(0, v); check("R8 empty read", v, {24'b0, 8'((sel * 17 + 16) & 8'hFF)});
    end

    // R9 transmit
    wr(17, 32'h30);
    wr(0, 32'h1234_565A);
    check("R9 tx strobe", {31'b0, tx_valid}, 32'h1);
    check("R9 tx byte", {24'b0, tx_byte}, 32'h5A);
    @(negedge clk);
    check("R9 tx one cycle", {31'b0, tx_valid}, 32'h0);
    rd(15, v); check("R9 tx raw", v, 32'h20);
    check("R10 irq masked off", {31'b0, irq}, 32'h0);

    // R10 mask, masked status, clear
    wr(13, 32'h08);             // threshold 4
    for (int k = 0; k < 4; k++) push(8'(k));
    rd(15, v); check("R10 raw both", v, 32'h30);
    wr(14, 32'h10);
    check("R10 irq rx", {31'b0, irq}, 32'h1);
    rd(16, v); check("R10 mis", v, 32'h10);
    wr(17, 32'h20);
    rd(15, v); check("R10 clear tx only", v, 32'h10);
    check("R10 irq still", {31'b0, irq}, 32'h1);
    wr(17, 32'h10);
    rd(15, v); check("R10 clear rx", v, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    wr(14, 32'h20);
    wr(0, 32'h77);
    check("R10 irq tx", {31'b0, irq}, 32'h1);
    rd(16, v); check("R10 mis tx", v, 32'h20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule